// File: doc/BRIEF.md
# External Interrupt Edge and Level Detector

This block watches sixteen asynchronous interrupt pins plus one non-maskable pin and turns chosen input conditions into sticky flags. Each pin is first brought into the clock domain by a synchroniser. If its filter is on, a three-sample majority vote then replaces the pin value. Finally the channel's sense mode decides whether a rising edge, a falling edge, either edge, a high level or a low level raises its flag. Software reads the flags and clears them by writing ones. A set/clear pair of enable registers masks which flags reach the single combined interrupt output.

The non-maskable pin has its own configuration nibble and its own flag. It drives a separate output that no enable bit can mask. All registers sit on a simple word-wide write port with a combinational read port.

Register map (word addresses): 0 holds channels 0–7 and 1 holds channels 8–15, four bits per channel with channel k at bits 4(k mod 8)+3..4(k mod 8). Address 2 sets enables, 3 clears enables, 4 holds the channel flags, 5 holds the non-maskable configuration nibble, and 6 holds the non-maskable flag at bit 0.

Top module: `extirq_detect`

## Requirements
- R1: After reset, all configuration fields, enables, channel flags and the non-maskable flag read as zero, and both outputs are low.
- R2: Rising mode (sense 1): with the filter off, a pin going high that the bus drove before clock edge N sets the channel flag at edge N+2, which is visible in flag register bit k after that edge.
- R3: Falling mode (sense 2) sets the flag only on a high-to-low change of the conditioned input.
- R4: Both-edges mode (sense 3) sets the flag on either kind of change and never while the input stays steady.
- R5: High-level mode (sense 4) sets the flag on every cycle the conditioned input is high, so a write-1 clear only takes effect once the input is low.
- R6: Low-level mode (sense 5) behaves like R5 for a low input.
- R7: Sense values 0, 6 and 7 never set a flag, whatever the pin does.
- R8: With the filter bit (bit 3 of the channel nibble) set, a one-cycle pin pulse is ignored, a two-cycle pulse is accepted, and a rising edge reaches the flag one cycle later than with the filter off.
- R9: Writing 1s to address 2 enables those channels and writing 1s to address 3 disables them; 0 bits leave the enable unchanged; both addresses read back the current enable vector.
- R10: Writing 1s to address 4 clears exactly those flag bits; a detection in the same cycle as the clear leaves the flag set.
- R11: The interrupt output is high exactly when some channel has both its flag and its enable set.
- R12: The non-maskable pin uses the same sense and filter coding via address 5. Its flag drives the non-maskable output regardless of the enables, and it is cleared by writing 1 to bit 0 of address 6.
- R13: Each configuration word packs eight channel nibbles as described above, reads back as written, and a nibble controls only its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Asynchronous interrupt pins, one per channel |
| nmi_pin_i | input | 1 | Asynchronous non-maskable pin |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Combined maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
A flag can be cleared by software in the same cycle that its channel detects a new event, and the two must not cancel each other. The bench arms a rising-edge channel whose flag is already set. It then times a write-1 clear so that the write commits on the same edge at which the new edge detection is pending, and expects the flag still to be set afterwards. For level modes, the same clear is issued while the level is still present and must have no effect; a second clear after the level drops must succeed.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

   typedef enum logic [2:0] {
      SENSE_OFF  = 3'd0,
      SENSE_RISE = 3'd1,
      SENSE_FALL = 3'd2,
      SENSE_BOTH = 3'd3,
      SENSE_HIGH = 3'd4,
      SENSE_LOW  = 3'd5
   } sense_e;

   typedef struct packed {
      logic       filt;
      logic [2:0] sense;
   } chan_cfg_t;

   localparam int CFG_FIELD_W = $bits(chan_cfg_t);

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int WIDTH  = 17,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("extirq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/extirq_chan.sv
module extirq_chan
   import extirq_pkg::*;
#(
   parameter int FILT_TAPS = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      din,
   input  chan_cfg_t cfg,
   output logic      hit
);

   localparam int CNT_W = $clog2(FILT_TAPS + 1);

   logic level;
   logic prev_q;
   logic rise;
   logic fall;

   if (FILT_TAPS == 1) begin : g_no_filter
      logic unused_filt;
      assign unused_filt = cfg.filt;
      assign level = din;
   end else begin : g_majority
      if (FILT_TAPS % 2 == 0) begin : g_bad_taps
         $error("extirq_chan: FILT_TAPS must be odd");
      end

      logic [FILT_TAPS-2:0] hist_q;
      logic [CNT_W-1:0]     votes;
      logic                 voted;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_q <= '0;
         end else begin
            hist_q[0] <= din;
            for (int t = 1; t < FILT_TAPS - 1; t++) begin
               hist_q[t] <= hist_q[t-1];
            end
         end
      end

      always_comb begin
         votes = CNT_W'(din);
         for (int t = 0; t < FILT_TAPS - 1; t++) begin
            votes = votes + CNT_W'(hist_q[t]);
         end
      end

      assign voted = (votes > CNT_W'(FILT_TAPS / 2));
      assign level = cfg.filt ? voted : din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;

   always_comb begin
      case (sense_e'(cfg.sense))
         SENSE_RISE: hit = rise;
         SENSE_FALL: hit = fall;
         SENSE_BOTH: hit = rise | fall;
         SENSE_HIGH: hit = level;
         SENSE_LOW:  hit = ~level;
         default:    hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
   import extirq_pkg::*;
#(
   parameter int NUM_CH      = 16,
   parameter int CH_PER_WORD = 8,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_i,
   input  logic              nmi_pin_i,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              nmi_o
);

   localparam int FIELD_W   = CFG_FIELD_W;
   localparam int NUM_WORDS = NUM_CH / CH_PER_WORD;
   localparam int A_EN_SET  = NUM_WORDS;
   localparam int A_EN_CLR  = NUM_WORDS + 1;
   localparam int A_FLAG    = NUM_WORDS + 2;
   localparam int A_NMI_CFG = NUM_WORDS + 3;
   localparam int A_NMI_FLG = NUM_WORDS + 4;
   localparam int N_IN      = NUM_CH + 1;

   if (NUM_CH % CH_PER_WORD != 0) begin : g_bad_pack
      $error("extirq_detect: NUM_CH must be a multiple of CH_PER_WORD");
   end
   if (CH_PER_WORD * FIELD_W > DATA_W) begin : g_bad_word
      $error("extirq_detect: configuration word wider than DATA_W");
   end
   if (NUM_CH > DATA_W) begin : g_bad_width
      $error("extirq_detect: NUM_CH exceeds DATA_W");
   end
   if (A_NMI_FLG >= (1 << ADDR_W)) begin : g_bad_addr
      $error("extirq_detect: ADDR_W too small for register map");
   end

   chan_cfg_t [NUM_CH-1:0] cfg_q;
   chan_cfg_t              nmi_cfg_q;
   logic [NUM_CH-1:0]      en_q;
   logic [NUM_CH-1:0]      flag_q;
   logic                   nmi_flag_q;
   logic [N_IN-1:0]        synced;
   logic [N_IN-1:0]        hit;

   logic                   wr_en_set;
   logic                   wr_en_clr;
   logic                   wr_flag;
   logic                   wr_nmi_cfg;
   logic                   wr_nmi_flg;
   logic [NUM_CH-1:0]      wmask;

   assign wr_en_set  = bus_we && (bus_addr == ADDR_W'(A_EN_SET));
   assign wr_en_clr  = bus_we && (bus_addr == ADDR_W'(A_EN_CLR));
   assign wr_flag    = bus_we && (bus_addr == ADDR_W'(A_FLAG));
   assign wr_nmi_cfg = bus_we && (bus_addr == ADDR_W'(A_NMI_CFG));
   assign wr_nmi_flg = bus_we && (bus_addr == ADDR_W'(A_NMI_FLG));
   assign wmask      = bus_wdata[NUM_CH-1:0];

   extirq_sync #(
      .WIDTH  (N_IN),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({nmi_pin_i, pin_i}),
      .sync_o  (synced)
   );

   for (genvar c = 0; c < N_IN; c++) begin : g_chan
      chan_cfg_t this_cfg;
      if (c < NUM_CH) begin : g_ext
         assign this_cfg = cfg_q[c];
      end else begin : g_nmi
         assign this_cfg = nmi_cfg_q;
      end

      extirq_chan #(
         .FILT_TAPS (FILT_TAPS)
      ) i_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (synced[c]),
         .cfg   (this_cfg),
         .hit   (hit[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (bus_we && (bus_addr == ADDR_W'(c / CH_PER_WORD))) begin
               cfg_q[c] <= bus_wdata[(c % CH_PER_WORD)*FIELD_W +: FIELD_W];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_cfg_q <= '0;
      end else if (wr_nmi_cfg) begin
         nmi_cfg_q <= bus_wdata[FIELD_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en_set) begin
         en_q <= en_q | wmask;
      end else if (wr_en_clr) begin
         en_q <= en_q & ~wmask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q     <= '0;
         nmi_flag_q <= 1'b0;
      end else begin
         flag_q     <= (flag_q & ~(wr_flag ? wmask : '0)) | hit[NUM_CH-1:0];
         nmi_flag_q <= (nmi_flag_q & ~(wr_nmi_flg & bus_wdata[0])) | hit[NUM_CH];
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ADDR_W'(c / CH_PER_WORD)) begin
            bus_rdata[(c % CH_PER_WORD)*FIELD_W +: FIELD_W] = cfg_q[c];
         end
      end
      if (bus_addr == ADDR_W'(A_EN_SET) || bus_addr == ADDR_W'(A_EN_CLR)) begin
         bus_rdata[NUM_CH-1:0] = en_q;
      end
      if (bus_addr == ADDR_W'(A_FLAG)) begin
         bus_rdata[NUM_CH-1:0] = flag_q;
      end
      if (bus_addr == ADDR_W'(A_NMI_CFG)) begin
         bus_rdata[FIELD_W-1:0] = nmi_cfg_q;
      end
      if (bus_addr == ADDR_W'(A_NMI_FLG)) begin
         bus_rdata[0] = nmi_flag_q;
      end
   end

   assign irq_o = |(flag_q & en_q);
   assign nmi_o = nmi_flag_q;

endmodule

// File: rtl/extirq_detect_chk.sv
module extirq_detect_chk #(
   parameter int NUM_CH      = 16,
   parameter int CH_PER_WORD = 8,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_we,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [DATA_W-1:0]        bus_wdata,
   input logic                     irq_o,
   input logic                     nmi_o,
   input logic [NUM_CH-1:0]        en_q,
   input logic [NUM_CH-1:0]        flag_q,
   input logic [NUM_CH:0]          hit,
   input logic [NUM_CH-1:0][3:0]   cfg_q
);

   localparam int NUM_WORDS = NUM_CH / CH_PER_WORD;
   localparam int A_EN_SET  = NUM_WORDS;
   localparam int A_EN_CLR  = NUM_WORDS + 1;
   localparam int A_NMI_FLG = NUM_WORDS + 4;

   // R1
   a_r1_reset_clean: assert property (@(posedge clk)
      (rst_n && !$past(rst_n)) |-> (flag_q == '0 && en_q == '0 && !irq_o && !nmi_o));

   // R9
   a_r9_en_set: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(A_EN_SET)) |=>
         ((en_q & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

   a_r9_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(A_EN_CLR)) |=>
         ((en_q & $past(bus_wdata[NUM_CH-1:0])) == '0));

   // R10
   a_r10_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(hit[NUM_CH-1:0])) == '0));

   a_r10_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[NUM_CH-1:0] != '0) |=>
         ((flag_q & $past(hit[NUM_CH-1:0])) == $past(hit[NUM_CH-1:0])));

   // R11
   a_r11_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flag_q != '0));

   a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq_o);

   // R12
   a_r12_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_o && !(bus_we && bus_addr == ADDR_W'(A_NMI_FLG) && bus_wdata[0])) |=> nmi_o);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_per_ch
      // R7
      a_r7_quiet_mode: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_q[i][2:0] == 3'd0 || cfg_q[i][2:0] == 3'd6 || cfg_q[i][2:0] == 3'd7)
            |-> !hit[i]);

      // R13
      a_r13_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(i / CH_PER_WORD)) |=>
            (cfg_q[i] == $past(bus_wdata[(i % CH_PER_WORD)*4 +: 4])));
   end

endmodule

bind extirq_detect extirq_detect_chk #(
   .NUM_CH      (NUM_CH),
   .CH_PER_WORD (CH_PER_WORD),
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .nmi_o     (nmi_o),
   .en_q      (en_q),
   .flag_q    (flag_q),
   .hit       (hit),
   .cfg_q     (cfg_q)
);

// File: tb/test_extirq_detect.sv
`timescale 1ns/1ps
module test_extirq_detect;

   localparam logic [2:0] A_CFG0 = 3'd0;
   localparam logic [2:0] A_CFG1 = 3'd1;
   localparam logic [2:0] A_ENS  = 3'd2;
   localparam logic [2:0] A_ENC  = 3'd3;
   localparam logic [2:0] A_FLG  = 3'd4;
   localparam logic [2:0] A_NCFG = 3'd5;
   localparam logic [2:0] A_NFLG = 3'd6;
   localparam logic [15:0] PAT   = 16'hA5C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pin_i = '0;
   logic        nmi_pin_i = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic        nmi_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] rd_val;

   always #5 clk = ~clk;

   extirq_detect i_extirq_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin_i),
      .nmi_pin_i (nmi_pin_i),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .nmi_o     (nmi_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [15:0] sweep_exp(input int m, input int step, input logic [15:0] p);
      case (m)
         1: return (step == 2) ? p : 16'h0;
         2: return (step == 4) ? p : 16'h0;
         3: return (step == 2 || step == 4) ? p : 16'h0;
         4: return (step == 2 || step == 3 || step == 4) ? p : 16'h0;
         5: return (step == 3) ? ~p : 16'hFFFF;
         default: return 16'h0;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_CFG0, rd_val); check("R1 cfg0", rd_val, 0);
      rd(A_CFG1, rd_val); check("R1 cfg1", rd_val, 0);
      rd(A_ENS,  rd_val); check("R1 en", rd_val, 0);
      rd(A_FLG,  rd_val); check("R1 flags", rd_val, 0);
      rd(A_NFLG, rd_val); check("R1 nmi flag", rd_val, 0);
      check("R1 outputs", {30'd0, irq_o, nmi_o}, 0);

      // Mode sweep: R2 R3 R4 R5 R6 R7, filter on and off (R8)
      for (int f = 0; f < 2; f++) begin
         for (int m = 0; m < 8; m++) begin
            logic [3:0] nib;
            string tag;
            nib = {f[0], m[2:0]};
            tag = $sformatf("R%0d mode%0d filt%0d", (m == 0 || m > 5) ? 7 : m + 1, m, f);
            wr(A_CFG0, {8{nib}});
            wr(A_CFG1, {8{nib}});
            idle(6);
            wr(A_FLG, 32'hFFFF);
            rd(A_FLG, rd_val); check({tag, " idle"}, rd_val, {16'h0, sweep_exp(m, 1, PAT)});
            @(negedge clk); pin_i = PAT;
            idle(6);
            rd(A_FLG, rd_val); check({tag, " raise"}, rd_val, {16'h0, sweep_exp(m, 2, PAT)});
            wr(A_FLG, 32'hFFFF);
            rd(A_FLG, rd_val); check({tag, " clr high"}, rd_val, {16'h0, sweep_exp(m, 3, PAT)});
            @(negedge clk); pin_i = '0;
            idle(6);
            rd(A_FLG, rd_val); check({tag, " drop"}, rd_val, {16'h0, sweep_exp(m, 4, PAT)});
            wr(A_FLG, 32'hFFFF);
            rd(A_FLG, rd_val); check({tag, " clr low"}, rd_val, {16'h0, sweep_exp(m, 5, PAT)});
         end
      end

      // R13 packing: ch2 rising, ch15 both edges filtered
      wr(A_CFG0, 32'h0000_0100);
      wr(A_CFG1, 32'hB000_0000);
      rd(A_CFG0, rd_val); check("R13 cfg0 readback", rd_val, 32'h0000_0100);
      rd(A_CFG1, rd_val); check("R13 cfg1 readback", rd_val, 32'hB000_0000);
      wr(A_FLG, 32'hFFFF);
      @(negedge clk); pin_i = 16'hFFFF;
      idle(6);
      rd(A_FLG, rd_val); check("R13 only own channels", rd_val, 32'h0000_8004);

      // R11 with flags 0x8004 and R9 enables
      rd(A_FLG, rd_val);
      check("R11 no enables", {31'd0, irq_o}, 0);
      wr(A_ENS, 32'h0000_0003);
      rd(A_ENS, rd_val); check("R9 set", rd_val, 32'h3);
      check("R11 enables miss flags", {31'd0, irq_o}, 0);
      wr(A_ENS, 32'h0000_0004);
      rd(A_ENC, rd_val); check("R9 set accumulates", rd_val, 32'h7);
      check("R11 enabled flag", {31'd0, irq_o}, 1);
      wr(A_ENC, 32'h0000_0005);
      rd(A_ENS, rd_val); check("R9 clear", rd_val, 32'h2);
      check("R11 flag masked again", {31'd0, irq_o}, 0);
      wr(A_ENS, 32'h0); wr(A_ENC, 32'h0);
      rd(A_ENS, rd_val); check("R9 zero writes", rd_val, 32'h2);
      wr(A_ENC, 32'hFFFF);
      @(negedge clk); pin_i = '0;
      idle(6);

      // R8 filter: ch0 rise filtered, ch1 rise unfiltered
      wr(A_CFG0, 32'h0000_0019);
      wr(A_CFG1, 32'h0);
      wr(A_FLG, 32'hFFFF);
      @(negedge clk); pin_i = 16'h0003;
      @(negedge clk); pin_i = 16'h0000;
      idle(6);
      rd(A_FLG, rd_val); check("R8 one-cycle pulse", rd_val, 32'h2);
      wr(A_FLG, 32'hFFFF);
      @(negedge clk); pin_i = 16'h0003;
      idle(2);
      pin_i = 16'h0000;
      idle(6);
      rd(A_FLG, rd_val); check("R8 two-cycle pulse", rd_val, 32'h3);
      wr(A_FLG, 32'hFFFF);
      bus_addr = A_FLG;
      @(negedge clk); pin_i = 16'h0003;
      @(negedge clk);
      @(negedge clk); #1 check("R2 no flag yet", bus_rdata, 32'h0);
      @(negedge clk); #1 check("R2 unfiltered latency", bus_rdata, 32'h2);
      @(negedge clk); #1 check("R8 filtered latency", bus_rdata, 32'h3);
      @(negedge clk); pin_i = '0;
      idle(6);

      // R10 selective clear
      wr(A_FLG, 32'h1);
      rd(A_FLG, rd_val); check("R10 selective clear", rd_val, 32'h2);

      // R10 clear meets new detection on ch1 (unfiltered)
      @(negedge clk); pin_i = 16'h0002;
      @(negedge clk);
      wr(A_FLG, 32'h2);
      rd(A_FLG, rd_val); check("R10 detection wins", rd_val, 32'h2);
      wr(A_FLG, 32'h2);
      rd(A_FLG, rd_val); check("R10 plain clear", rd_val, 32'h0);
      @(negedge clk); pin_i = '0;
      idle(6);

      // R5 level clear only after level gone
      wr(A_CFG0, 32'h0000_0004);
      @(negedge clk); pin_i = 16'h0001;
      idle(6);
      wr(A_FLG, 32'h1);
      rd(A_FLG, rd_val); check("R5 clear while high", rd_val, 32'h1);
      @(negedge clk); pin_i = '0;
      idle(6);
      wr(A_FLG, 32'h1);
      rd(A_FLG, rd_val); check("R5 clear after low", rd_val, 32'h0);

      // R12 non-maskable channel
      wr(A_NCFG, 32'h1);
      rd(A_NCFG, rd_val); check("R12 cfg readback", rd_val, 32'h1);
      @(negedge clk); nmi_pin_i = 1'b1;
      idle(6);
      rd(A_NFLG, rd_val); check("R12 flag", rd_val, 32'h1);
      check("R12 output unmasked", {30'd0, nmi_o, irq_o}, 32'h2);
      wr(A_NFLG, 32'h1);
      rd(A_NFLG, rd_val); check("R12 clear", rd_val, 32'h0);
      check("R12 output low", {31'd0, nmi_o}, 0);

      report();
   end

endmodule